// File: doc/BRIEF.md
# Three-Line Vertical Sharpening Filter

This block sharpens 8-bit image data across scan lines. On every accepted sample it receives three vertically aligned pixels: the pixel from the line above (A), the centre-line pixel (N) and the pixel from the line below (B). The line above comes from a two-line delay and the centre line from a one-line delay. The line below comes straight from the input stream. The block produces a corrected centre pixel equal to N plus the vertical second difference 2N-(A+B), scaled by a programmable gain K.

K is unsigned fixed point with four integer bits and four fractional bits, so 16 means a gain of one. The scaled term is rounded to the nearest integer and added to N. The sum is then clamped to 0..255. The arithmetic runs in three registered stages. A valid flag travels alongside the data, so each result leaves with its own strobe. The line delays that feed the three taps sit outside this block.

Top module: `vsharp_filter`

## Requirements
- R1: For an accepted sample, out_pix = clamp(N + floor((K*(2N-A-B) + 8) / 16)) with clamp to 0..255. K is the unsigned 8-bit in_k, where 16 means a gain of one, and A = in_a, N = in_n, B = in_b. A product ending in exactly .5 rounds toward positive.
- R2: A sample taken with in_valid high at a rising edge appears on out_pix with out_valid high after exactly three rising edges.
- R3: In a flat region (A = N = B) the output equals N for every K.
- R4: With K = 0 the output equals N whatever A and B are.
- R5: A result above 255 is clamped to 255.
- R6: A result below 0 is clamped to 0.
- R7: Inputs present while in_valid is low are ignored. out_valid is low three edges later and out_pix keeps its last value.
- R8: While rst_n is low, out_valid and out_pix are 0.
- R9: Samples on back-to-back cycles each give a result, one per cycle, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe for the three pixel taps |
| in_a | input | 8 | Pixel from the line above (two-line delay tap) |
| in_n | input | 8 | Centre pixel (one-line delay tap) |
| in_b | input | 8 | Pixel from the line below (direct input) |
| in_k | input | 8 | Gain, unsigned, 4 integer and 4 fractional bits |
| out_valid | output | 1 | Result strobe, three cycles after in_valid |
| out_pix | output | 8 | Sharpened, clamped centre pixel |

## Verification
The checker's properties assume that in_valid stays low from the start of reset until the internal reset has been released. They also look back three cycles only after a short warm-up count, so the pipeline always holds samples taken after reset. The bench holds in_valid low through that warm-up. It then mixes seeded random pixels and gains, with in_valid high about three quarters of the time, among directed flat, zero-gain, rounding-tie and saturation cases. Every drive and every sample happens on the falling clock edge.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;
  localparam int unsigned VS_PIX_W  = 8;
  localparam int unsigned VS_K_INT  = 4;
  localparam int unsigned VS_K_FRAC = 4;

  function automatic int unsigned diff_width(input int unsigned pix_w);
    return pix_w + 3;
  endfunction

  function automatic int unsigned prod_width(input int unsigned pix_w, input int unsigned k_w);
    return pix_w + 3 + k_w + 1;
  endfunction
endpackage

// File: rtl/vsharp_sum_stage.sv
module vsharp_sum_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned K_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] n_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [K_W-1:0]   k_i,
  output logic             vld_q,
  output logic [PIX_W:0]   pair_q,
  output logic [PIX_W:0]   twice_q,
  output logic [PIX_W-1:0] n_q,
  output logic [K_W-1:0]   k_q
);
  logic [PIX_W:0] pair_d;
  logic [PIX_W:0] twice_d;

  always_comb begin
    pair_d  = {1'b0, a_i} + {1'b0, b_i};
    twice_d = {n_i, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      pair_q  <= '0;
      twice_q <= '0;
      n_q     <= '0;
      k_q     <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        pair_q  <= pair_d;
        twice_q <= twice_d;
        n_q     <= n_i;
        k_q     <= k_i;
      end
    end
  end
endmodule

// File: rtl/vsharp_scale_stage.sv
module vsharp_scale_stage #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned K_W    = 8,
  parameter int unsigned DIFF_W = 11,
  parameter int unsigned PROD_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic [PIX_W:0]           pair_i,
  input  logic [PIX_W:0]           twice_i,
  input  logic [PIX_W-1:0]         n_i,
  input  logic [K_W-1:0]           k_i,
  output logic                     vld_q,
  output logic signed [PROD_W-1:0] prod_q,
  output logic [PIX_W-1:0]         n_q
);
  localparam int unsigned PAD_W = DIFF_W - (PIX_W + 1);

  logic signed [DIFF_W-1:0] diff_d;
  logic signed [PROD_W-1:0] diff_x;
  logic signed [PROD_W-1:0] gain_x;
  logic signed [PROD_W-1:0] prod_d;

  always_comb begin
    diff_d = $signed({{PAD_W{1'b0}}, twice_i}) - $signed({{PAD_W{1'b0}}, pair_i});
    diff_x = PROD_W'(diff_d);
    gain_x = $signed(PROD_W'({1'b0, k_i}));
    prod_d = diff_x * gain_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
      n_q    <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        prod_q <= prod_d;
        n_q    <= n_i;
      end
    end
  end
endmodule

// File: rtl/vsharp_clamp_stage.sv
module vsharp_clamp_stage #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned K_FRAC = 4,
  parameter int unsigned PROD_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic [PIX_W-1:0]         n_i,
  output logic                     vld_q,
  output logic [PIX_W-1:0]         pix_q
);
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'((2 ** K_FRAC) / 2);
  localparam logic signed [PROD_W-1:0] PIXMAX = PROD_W'((2 ** PIX_W) - 1);

  logic signed [PROD_W-1:0] rounded;
  logic signed [PROD_W-1:0] total;
  logic [PIX_W-1:0]         pix_d;

  always_comb begin
    rounded = (prod_i + HALF) >>> K_FRAC;
    total   = rounded + $signed(PROD_W'(n_i));
    if (total < 0)
      pix_d = '0;
    else if (total > PIXMAX)
      pix_d = '1;
    else
      pix_d = total[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i)
        pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/vsharp_filter.sv
module vsharp_filter
  import vsharp_pkg::*;
#(
  parameter int unsigned PIX_W  = VS_PIX_W,
  parameter int unsigned K_INT  = VS_K_INT,
  parameter int unsigned K_FRAC = VS_K_FRAC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_a,
  input  logic [PIX_W-1:0]         in_n,
  input  logic [PIX_W-1:0]         in_b,
  input  logic [K_INT+K_FRAC-1:0]  in_k,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pix
);
  localparam int unsigned K_W    = K_INT + K_FRAC;
  localparam int unsigned DIFF_W = diff_width(PIX_W);
  localparam int unsigned PROD_W = prod_width(PIX_W, K_W);

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             s1_vld;
  logic [PIX_W:0]   s1_pair;
  logic [PIX_W:0]   s1_twice;
  logic [PIX_W-1:0] s1_n;
  logic [K_W-1:0]   s1_k;

  vsharp_sum_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_sum (
    .clk(clk), .rst_n(rst_sync_q), .vld_i(in_valid),
    .a_i(in_a), .n_i(in_n), .b_i(in_b), .k_i(in_k),
    .vld_q(s1_vld), .pair_q(s1_pair), .twice_q(s1_twice), .n_q(s1_n), .k_q(s1_k)
  );

  logic                     s2_vld;
  logic signed [PROD_W-1:0] s2_prod;
  logic [PIX_W-1:0]         s2_n;

  vsharp_scale_stage #(.PIX_W(PIX_W), .K_W(K_W), .DIFF_W(DIFF_W), .PROD_W(PROD_W)) u_scale (
    .clk(clk), .rst_n(rst_sync_q), .vld_i(s1_vld),
    .pair_i(s1_pair), .twice_i(s1_twice), .n_i(s1_n), .k_i(s1_k),
    .vld_q(s2_vld), .prod_q(s2_prod), .n_q(s2_n)
  );

  vsharp_clamp_stage #(.PIX_W(PIX_W), .K_FRAC(K_FRAC), .PROD_W(PROD_W)) u_clamp (
    .clk(clk), .rst_n(rst_sync_q), .vld_i(s2_vld),
    .prod_i(s2_prod), .n_i(s2_n),
    .vld_q(out_valid), .pix_q(out_pix)
  );
endmodule

// File: rtl/vsharp_filter_chk.sv
module vsharp_filter_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned K_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_a,
  input logic [PIX_W-1:0] in_n,
  input logic [PIX_W-1:0] in_b,
  input logic [K_W-1:0]   in_k,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  logic [2:0] warm_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      warm_q <= '0;
    else if (warm_q != 3'd7)
      warm_q <= warm_q + 3'd1;
  end

  assign live = (warm_q == 3'd7);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    out_valid == $past(in_valid, 3));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !out_valid |-> $stable(out_pix));

  assert_flat_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(in_valid && in_a == in_n && in_b == in_n, 3) |-> out_pix == $past(in_n, 3));

  assert_zero_gain_R4: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(in_valid && in_k == '0, 3) |-> out_pix == $past(in_n, 3));
endmodule

bind vsharp_filter vsharp_filter_chk #(.PIX_W(PIX_W), .K_W(K_INT + K_FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_n(in_n),
  .in_b(in_b), .in_k(in_k), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/sim_vsharp_filter.sv
module sim_vsharp_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_a, in_n, in_b, in_k;
  logic       out_valid;
  logic [7:0] out_pix;

  int errors;
  int checks;
  int cycles;

  logic     pv [3];
  int       pe [3];
  string    pt [3];
  int       last_pix;

  vsharp_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_n(in_n),
    .in_b(in_b), .in_k(in_k), .out_valid(out_valid), .out_pix(out_pix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int model(input int a, input int n, input int b, input int k);
    int p, r, v;
    p = (2 * n - a - b) * k;
    r = (p + 8) >>> 4;
    v = n + r;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input int a, input int n, input int b, input int k,
                      input string tag);
    @(negedge clk);
    check({pt[2], " valid"}, int'(out_valid), int'(pv[2]));
    if (pv[2]) begin
      check({pt[2], " pixel"}, int'(out_pix), pe[2]);
      last_pix = pe[2];
    end else begin
      check({pt[2], " hold"}, int'(out_pix), last_pix);
    end
    pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v; pe[0] = model(a, n, b, k); pt[0] = tag;
    in_valid = v;
    in_a = 8'(a); in_n = 8'(n); in_b = 8'(b); in_k = 8'(k);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    errors = 0; checks = 0; last_pix = 0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pe[i] = 0; pt[i] = "R7 idle"; end
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 1'b0; in_a = 8'd0; in_n = 8'd0; in_b = 8'd0; in_k = 8'd0;
    repeat (3) @(negedge clk);
    in_a = 8'd200; in_n = 8'd200; in_b = 8'd1; in_k = 8'd16;
    @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    check("R8 reset pixel", int'(out_pix), 0);
    rst_n = 1'b1;
    in_a = 8'd0; in_n = 8'd0; in_b = 8'd0; in_k = 8'd0;
    repeat (8) @(negedge clk);

    step(1'b1, 100, 100, 100, 255, "R3 flat high gain");
    step(1'b1, 7, 7, 7, 16, "R3 flat");
    step(1'b1, 0, 128, 0, 0, "R4 zero gain");
    step(1'b1, 0, 128, 128, 8, "R1 edge");
    step(1'b1, 10, 10, 9, 8, "R1 round up");
    step(1'b1, 10, 10, 11, 8, "R1 tie toward positive");
    step(1'b1, 0, 255, 0, 16, "R5 clamp high");
    step(1'b1, 255, 0, 255, 16, "R6 clamp low");
    step(1'b1, 40, 200, 40, 255, "R5 clamp high max gain");
    step(1'b1, 255, 30, 200, 255, "R6 clamp low max gain");
    step(1'b0, 255, 0, 255, 200, "R7 ignored");
    step(1'b0, 0, 255, 0, 200, "R7 ignored");
    step(1'b1, 50, 60, 70, 24, "R9 back to back");
    step(1'b1, 90, 80, 70, 24, "R9 back to back");
    step(1'b1, 20, 60, 30, 3, "R9 back to back");
    step(1'b0, 1, 2, 3, 4, "R7 ignored");

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256,
           $urandom % 256, "R1 R2 random");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, "R2 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule